// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block narrows an IEEE-754 binary32 word to an IEEE-754 binary16 word in one registered stage. A two-bit input selects the rounding direction for each conversion. A word is accepted when its strobe is high. The converted half-precision word and its strobe appear on the output one clock later.

The datapath first sorts the input into one of these classes: NaN, infinity, zero, overflow, underflow, subnormal result or normal result. Exceptional classes are turned into fixed patterns that depend on the sign and the rounding direction. The two finite classes take a right shift of the significand, a mode-dependent increment, and a carry fix-up. The carry fix-up lets a rounded fraction spill into the exponent field. Binary32 subnormal inputs take the ordinary path and always land in the underflow class.

The output word is held while the strobe is low. The output strobe falls in the first cycle after an idle input.

Top module: `fp32_to_fp16_conv`

## Requirements
- R1: `out_valid_o` equals the value `in_valid_i` had at the previous rising clock edge. Reset (`rst_ni` low, asynchronous) clears `out_valid_o` and `out_word_o` to zero.
- R2: A NaN input (exponent field 0xFF, nonzero fraction) gives the input sign, exponent 0x1F, and fraction bits [22:13] with output bit 9 forced to 1.
- R3: An infinite input (exponent field 0xFF, zero fraction) gives the input sign, exponent 0x1F and fraction 0.
- R4: A zero input (exponent and fraction fields both 0) gives a zero with the input sign.
- R5: With an unbiased exponent of 16 or more (field 143..254), the output is the sign with magnitude 0x7BFF in three cases: mode 1, a negative value in mode 2, and a positive value in mode 3. In every other case it is the signed infinity 0x7C00.
- R6: With an unbiased exponent below -25 (field below 102, nonzero), the output is a signed zero. The exceptions are a positive value in mode 2, which gives 0x0001, and a negative value in mode 3, which gives 0x8001.
- R7: With an unbiased exponent from -25 to -15, the output exponent is 0. The fraction is the 24-bit significand (implicit one restored) shifted right by (-exponent - 1).
- R8: Mode 0 (nearest, ties to even) rounds up when the discarded bits exceed half an output LSB. At exactly half, it rounds up only when the kept LSB is 1.
- R9: Mode 1 (toward zero) never rounds up. Mode 2 (toward +infinity) rounds up only positive inexact values. Mode 3 (toward -infinity) rounds up the magnitude only of negative inexact values.
- R10: A rounding carry out of the 10-bit fraction increments the exponent and clears the fraction. A subnormal can thus become 0x0400, and a value just below 2^16 can become infinity.
- R11: While `in_valid_i` is low, `out_word_o` keeps its previous value whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word strobe |
| in_word_i | input | 32 | binary32 operand (sign bit 31, exponent 30:23, fraction 22:0) |
| rnd_mode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid_o | output | 1 | Result strobe, one cycle after the input strobe |
| out_word_o | output | 16 | binary16 result (sign bit 15, exponent 14:10, fraction 9:0) |

## Verification
The only state in the block is the output register, so a misclassified operand shows up on `out_word_o` in the cycle right after its strobe. Examples are a wrong overflow or subnormal boundary, or a wrong shift amount or increment decision. Each such fault shows only for the exponent or tie pattern that reaches it. The sweep therefore crosses every rounding mode and both signs with every exponent field near the half-precision range. It uses fraction patterns that put ties, sticky bits and all-ones carries at the rounding position. A fault in the strobe or in the hold logic shows as a stale or overwritten word one cycle after an idle input.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_PLUS    = 2'd2,
    RM_MINUS   = 2'd3
  } rnd_mode_e;

  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_SUB,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN,
    CLS_OVF,
    CLS_UNF
  } num_cls_e;

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
#(
  parameter int SRC_EXP = 8,
  parameter int SRC_MAN = 23,
  parameter int DST_EXP = 5,
  parameter int DST_MAN = 10,
  localparam int SRC_W  = 1 + SRC_EXP + SRC_MAN,
  localparam int SIG_W  = SRC_MAN + 1,
  localparam int SHW    = $clog2(SIG_W + 1)
) (
  input  logic [SRC_W-1:0]   word_i,
  output logic               sign_o,
  output num_cls_e           cls_o,
  output logic [SIG_W-1:0]   sig_o,
  output logic [SHW-1:0]     shamt_o,
  output logic [DST_EXP-1:0] exp_o,
  output logic [DST_MAN-1:0] nan_frac_o
);
  localparam int EW       = SRC_EXP + 2;
  localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
  localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
  localparam int NSH      = SRC_MAN - DST_MAN;
  localparam logic signed [EW-1:0] E_OVF   = EW'(DST_BIAS + 1);
  localparam logic signed [EW-1:0] E_SUB   = EW'(1 - DST_BIAS);
  localparam logic signed [EW-1:0] E_UNF   = EW'(1 - DST_BIAS - DST_MAN - 1);
  localparam logic signed [EW-1:0] E_SBIAS = EW'(SRC_BIAS);
  localparam logic signed [EW-1:0] E_DBIAS = EW'(DST_BIAS);
  localparam logic signed [EW-1:0] E_NSH   = EW'(NSH);

  logic [SRC_EXP-1:0] exp_f;
  logic [SRC_MAN-1:0] frac_f;
  logic signed [EW-1:0] unb, sub_sh, biased;

  assign {sign_o, exp_f, frac_f} = word_i;
  assign unb    = $signed({2'b00, exp_f}) - E_SBIAS;
  assign sub_sh = E_NSH + E_SUB - unb;
  assign biased = unb + E_DBIAS;

  // quiet bit forced, payload truncated from the top
  assign nan_frac_o = {1'b1, frac_f[SRC_MAN-2 -: DST_MAN-1]};

  always_comb begin
    cls_o   = CLS_NORM;
    sig_o   = {1'b0, frac_f};
    shamt_o = SHW'(NSH);
    exp_o   = DST_EXP'(biased);
    if (&exp_f) begin
      cls_o = (|frac_f) ? CLS_NAN : CLS_INF;
    end else if (exp_f == '0 && frac_f == '0) begin
      cls_o = CLS_ZERO;
    end else if (unb >= E_OVF) begin
      cls_o = CLS_OVF;
    end else if (unb < E_UNF) begin
      cls_o = CLS_UNF;
    end else if (unb < E_SUB) begin
      cls_o   = CLS_SUB;
      sig_o   = {1'b1, frac_f};
      shamt_o = SHW'(sub_sh);
      exp_o   = '0;
    end
  end

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
#(
  parameter int SIG_W  = 24,
  parameter int SHW    = 5,
  parameter int KEEP_W = 11
) (
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [SHW-1:0]    shamt_i,
  input  rnd_mode_e         mode_i,
  input  logic              sign_i,
  output logic [KEEP_W-1:0] mant_o
);
  logic [2*SIG_W-1:0] ext;
  logic [KEEP_W-1:0]  kept;
  logic               guard, sticky, inexact, inc;

  assign ext     = {sig_i, {SIG_W{1'b0}}} >> shamt_i;
  assign kept    = KEEP_W'(ext[2*SIG_W-1:SIG_W]);
  assign guard   = ext[SIG_W-1];
  assign sticky  = |ext[SIG_W-2:0];
  assign inexact = guard | sticky;

  always_comb begin
    case (mode_i)
      RM_NEAREST: inc = guard & (sticky | kept[0]);
      RM_ZERO:    inc = 1'b0;
      RM_PLUS:    inc = inexact & ~sign_i;
      RM_MINUS:   inc = inexact & sign_i;
      default:    inc = 1'b0;
    endcase
  end

  assign mant_o = kept + KEEP_W'(inc);

endmodule

// File: rtl/fcvt_special.sv
module fcvt_special
  import fcvt_pkg::*;
#(
  parameter int DST_EXP = 5,
  parameter int DST_MAN = 10,
  localparam int DST_W  = 1 + DST_EXP + DST_MAN
) (
  input  num_cls_e           cls_i,
  input  logic               sign_i,
  input  rnd_mode_e          mode_i,
  input  logic [DST_MAN-1:0] nan_frac_i,
  output logic [DST_W-1:0]   word_o
);
  localparam logic [DST_EXP-1:0] EXP_TOP = {{(DST_EXP-1){1'b1}}, 1'b0};

  logic to_max, to_tiny;

  assign to_max  = (mode_i == RM_ZERO) | (mode_i == RM_PLUS & sign_i) |
                   (mode_i == RM_MINUS & ~sign_i);
  assign to_tiny = (mode_i == RM_PLUS & ~sign_i) | (mode_i == RM_MINUS & sign_i);

  always_comb begin
    case (cls_i)
      CLS_NAN: word_o = {sign_i, {DST_EXP{1'b1}}, nan_frac_i};
      CLS_INF: word_o = {sign_i, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
      CLS_OVF: word_o = to_max ? {sign_i, EXP_TOP, {DST_MAN{1'b1}}}
                               : {sign_i, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
      CLS_UNF: word_o = {sign_i, {DST_EXP{1'b0}}, DST_MAN'(to_tiny)};
      default: word_o = {sign_i, {(DST_W-1){1'b0}}};
    endcase
  end

endmodule

// File: rtl/fp32_to_fp16_conv.sv
module fp32_to_fp16_conv
  import fcvt_pkg::*;
#(
  parameter int SRC_EXP = 8,
  parameter int SRC_MAN = 23,
  parameter int DST_EXP = 5,
  parameter int DST_MAN = 10,
  localparam int SRC_W  = 1 + SRC_EXP + SRC_MAN,
  localparam int DST_W  = 1 + DST_EXP + DST_MAN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SRC_W-1:0] in_word_i,
  input  logic [1:0]       rnd_mode_i,
  output logic             out_valid_o,
  output logic [DST_W-1:0] out_word_o
);
  localparam int SIG_W  = SRC_MAN + 1;
  localparam int KEEP_W = DST_MAN + 1;
  localparam int SHW    = $clog2(SIG_W + 1);

  rnd_mode_e          mode;
  logic               sign;
  num_cls_e           cls;
  logic [SIG_W-1:0]   sig;
  logic [SHW-1:0]     shamt;
  logic [DST_EXP-1:0] exp_c, exp_n;
  logic [DST_MAN-1:0] nan_frac, frac_n;
  logic [KEEP_W-1:0]  mant_r;
  logic [DST_W-1:0]   special, result;

  assign mode = rnd_mode_e'(rnd_mode_i);

  fcvt_classify #(
    .SRC_EXP(SRC_EXP), .SRC_MAN(SRC_MAN), .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)
  ) u_cls (
    .word_i    (in_word_i),
    .sign_o    (sign),
    .cls_o     (cls),
    .sig_o     (sig),
    .shamt_o   (shamt),
    .exp_o     (exp_c),
    .nan_frac_o(nan_frac)
  );

  fcvt_round #(
    .SIG_W(SIG_W), .SHW(SHW), .KEEP_W(KEEP_W)
  ) u_rnd (
    .sig_i  (sig),
    .shamt_i(shamt),
    .mode_i (mode),
    .sign_i (sign),
    .mant_o (mant_r)
  );

  fcvt_special #(
    .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)
  ) u_spc (
    .cls_i     (cls),
    .sign_i    (sign),
    .mode_i    (mode),
    .nan_frac_i(nan_frac),
    .word_o    (special)
  );

  // rounding carry spills into the exponent
  always_comb begin
    if (mant_r[KEEP_W-1]) begin
      exp_n  = exp_c + DST_EXP'(1);
      frac_n = '0;
    end else begin
      exp_n  = exp_c;
      frac_n = mant_r[DST_MAN-1:0];
    end
  end

  assign result = (cls == CLS_NORM || cls == CLS_SUB) ? {sign, exp_n, frac_n} : special;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_word_o <= result;
    end
  end

endmodule

// File: rtl/fcvt_checker.sv
module fcvt_checker #(
  parameter int SRC_EXP = 8,
  parameter int SRC_MAN = 23,
  parameter int DST_EXP = 5,
  parameter int DST_MAN = 10,
  localparam int SRC_W  = 1 + SRC_EXP + SRC_MAN,
  localparam int DST_W  = 1 + DST_EXP + DST_MAN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [SRC_W-1:0] in_word_i,
  input logic [1:0]       rnd_mode_i,
  input logic             out_valid_o,
  input logic [DST_W-1:0] out_word_o
);
  localparam int SRC_BIAS  = (1 << (SRC_EXP - 1)) - 1;
  localparam int DST_BIAS  = (1 << (DST_EXP - 1)) - 1;
  localparam logic [SRC_EXP-1:0] OVF_FIELD = SRC_EXP'(SRC_BIAS + DST_BIAS + 1);
  localparam logic [SRC_EXP-1:0] UNF_FIELD = SRC_EXP'(SRC_BIAS - DST_BIAS - DST_MAN);
  localparam logic [DST_W-2:0] MAG_MAX = {{(DST_EXP-1){1'b1}}, 1'b0, {DST_MAN{1'b1}}};
  localparam logic [DST_W-2:0] MAG_INF = {{DST_EXP{1'b1}}, {DST_MAN{1'b0}}};

  logic               s_in;
  logic [SRC_EXP-1:0] e_in;
  logic [SRC_MAN-1:0] f_in;
  logic               is_top, is_nan, is_inf, is_zero, is_ovf, is_unf;

  assign {s_in, e_in, f_in} = in_word_i;
  assign is_top  = &e_in;
  assign is_nan  = is_top & (|f_in);
  assign is_inf  = is_top & ~(|f_in);
  assign is_zero = (e_in == '0) & (f_in == '0);
  assign is_ovf  = ~is_top & (e_in >= OVF_FIELD);
  assign is_unf  = ~is_zero & (e_in < UNF_FIELD);

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r1_idle_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_word_o));
  a_r2_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_nan) |=> (&out_word_o[DST_W-2 -: DST_EXP]) && out_word_o[DST_MAN-1]
                               && out_word_o[DST_W-1] == $past(s_in));
  a_r3_inf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_inf) |=> out_word_o == {$past(s_in), MAG_INF});
  a_r4_signed_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_zero) |=> out_word_o == {$past(s_in), {(DST_W-1){1'b0}}});
  a_r5_overflow_mag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_ovf) |=> out_word_o[DST_W-1] == $past(s_in) &&
      (out_word_o[DST_W-2:0] == MAG_MAX || out_word_o[DST_W-2:0] == MAG_INF));
  a_r6_underflow_tiny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_unf) |=> out_word_o[DST_W-2:1] == '0);
  a_r9_zero_mode_finite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !is_top && rnd_mode_i == 2'd1) |=> !(&out_word_o[DST_W-2 -: DST_EXP]));

endmodule

bind fp32_to_fp16_conv fcvt_checker u_chk (.*);

// File: tb/sim_fp32_to_fp16_conv.sv
`timescale 1ns/1ps
module sim_fp32_to_fp16_conv;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        in_valid;
  logic [31:0] in_word;
  logic [1:0]  md;
  logic        out_valid;
  logic [15:0] out_word;

  int n_chk = 0;
  int n_fail = 0;
  bit          pend = 1'b0;
  logic [15:0] pend_exp, last_out;
  logic [31:0] pend_in;
  logic [1:0]  pend_md;
  string       pend_tag;

  always #10 clk = ~clk;

  fp32_to_fp16_conv u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_word_i(in_word),
    .rnd_mode_i(md), .out_valid_o(out_valid), .out_word_o(out_word)
  );

  // Quantum-based model: value = m * 2^(eu-23), result step 2^qe
  function automatic logic [15:0] ref_cvt(input logic [31:0] w, input logic [1:0] m,
                                          output string tag);
    logic s;
    int ef, eu, qe, r, be, be_nom;
    longint sig, n, rem, half;
    bit up;
    logic [15:0] res;
    s  = w[31];
    ef = int'(w[30:23]);
    eu = ef - 127;
    if (ef == 255) begin
      tag = (w[22:0] != 0) ? "R2" : "R3";
      return (w[22:0] != 0) ? {s, 5'h1f, 1'b1, w[21:13]} : {s, 15'h7c00};
    end
    if (ef == 0 && w[22:0] == 0) begin tag = "R4"; return {s, 15'h0}; end
    if (eu >= 16) begin
      tag = "R5";
      if (m == 2'd1 || (m == 2'd2 && s) || (m == 2'd3 && !s)) return {s, 15'h7bff};
      return {s, 15'h7c00};
    end
    if (eu < -25) begin
      tag = "R6";
      if ((m == 2'd2 && !s) || (m == 2'd3 && s)) return {s, 15'h0001};
      return {s, 15'h0};
    end
    sig  = longint'({1'b1, w[22:0]});
    qe   = (eu < -14) ? -24 : eu - 10;
    r    = qe - (eu - 23);
    n    = sig >> r;
    rem  = sig & ((longint'(1) << r) - 1);
    half = longint'(1) << (r - 1);
    case (m)
      2'd0:    up = (rem > half) || (rem == half && n[0]);
      2'd2:    up = (rem != 0) && !s;
      2'd3:    up = (rem != 0) && s;
      default: up = 1'b0;
    endcase
    n = n + longint'(up);
    if (n == 2048) begin n = 1024; qe = qe + 1; end
    be_nom = (eu < -14) ? 0 : eu + 15;
    if (n < 1024) res = {s, 5'd0, n[9:0]};
    else begin
      be = qe + 25;
      if (be >= 31) res = {s, 15'h7c00};
      else begin n = n - 1024; res = {s, be[4:0], n[9:0]}; end
    end
    if (int'(res[14:10]) != be_nom) tag = "R10";
    else if (eu < -14) tag = "R7";
    else if (m == 2'd0) tag = "R8";
    else tag = "R9";
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic [1:0] m, input bit v);
    string t;
    logic [15:0] e;
    @(negedge clk);
    if (pend) begin
      check(out_valid == 1'b1, "R1", "strobe after accepted word", {15'b0, out_valid}, 16'h1);
      check(out_word == pend_exp, pend_tag, $sformatf("in %h mode %0d", pend_in, pend_md),
            out_word, pend_exp);
      last_out = out_word;
    end else begin
      check(out_valid == 1'b0, "R1", "strobe low after idle", {15'b0, out_valid}, 16'h0);
      check(out_word == last_out, "R11", "word held while idle", out_word, last_out);
    end
    in_word  = w;
    md       = m;
    in_valid = v;
    pend     = v;
    if (v) begin
      e = ref_cvt(w, m, t);
      pend_exp = e; pend_tag = t; pend_in = w; pend_md = m;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [22:0] pats [14];
    pats = '{23'h000000, 23'h000001, 23'h000fff, 23'h001000, 23'h001001, 23'h002000,
             23'h003000, 23'h7fffff, 23'h7ff000, 23'h400000, 23'h7fefff, 23'h0,
             23'h0, 23'h0};
    rst_ni = 1'b0; in_valid = 1'b0; in_word = '0; md = '0; last_out = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset strobe", {15'b0, out_valid}, 16'h0);
    check(out_word == 16'h0, "R1", "reset word", out_word, 16'h0);
    rst_ni = 1'b1;
    for (int mi = 0; mi < 4; mi++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int ef = 0; ef < 256; ef++) begin
          if (ef <= 1 || (ef >= 100 && ef <= 146) || ef >= 254) begin
            pats[11] = 23'($urandom);
            pats[12] = 23'($urandom);
            pats[13] = 23'($urandom);
            for (int pi = 0; pi < 14; pi++)
              step({sg[0], ef[7:0], pats[pi]}, mi[1:0], 1'b1);
            step($urandom, mi[1:0], 1'b0);
          end
        end
      end
    end
    step(32'h3f800000, 2'd0, 1'b0);
    step(32'h0, 2'd0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule